// File: doc/BRIEF.md
# Iterative Divide and Square-Root Coprocessor

This block is an arithmetic helper that sits on a simple register port. Software loads operands into registers, the unit works on them over several clock cycles, and software then reads a single result register. It handles 32-bit division, signed or unsigned, returning either the quotient or the remainder. It also computes the integer square root of a 32-bit unsigned value, giving a 16-bit root.

Division can be started in two ways. In the default mode, writing the divisor starts it. In the deferred mode, software writes the operands first and then starts the division by writing the control register with its go bit set. A packed three-bit status code shows whether the unit is busy and which operation ran last. A zero divisor raises a sticky flag. When the trap enable is also set, reading the result ends with an error response on the port.

The port accepts a request in every cycle (`req_ready` is held high). Read data and the error line are combinational from the addressed register.

Top module: `divsqrt_unit`

## Requirements
- R1: After reset, the control register (address 0) reads 0, which means status code 0 and the deferred-start bit clear. The result register (address 4) and the dividend register (address 1) also read 0, and reads return no error.
- R2: For an unsigned division (control bit 1 = 1), the unit is busy for exactly 32 cycles after the cycle in which the start is captured. During that time the status field, control bits [31:29], reads 6. Afterwards it reads 2, and the result is the truncated quotient.
- R3: For a signed division (control bit 1 = 0), the quotient is negative exactly when the operand signs differ, and the remainder takes the sign of the dividend. Both use truncating semantics.
- R4: Control bit 2, as set when the division starts, makes the result register return the remainder instead of the quotient.
- R5: When control bit 4 is 0, a write to the divisor register (address 2) while the unit is idle starts a division at once, using the stored dividend.
- R6: When control bit 4 is 1, a divisor write does not start anything. A division starts only when the control register is written with bit 0 (go) and bit 4 both set, and that write's bits 1 and 2 apply to it.
- R7: A division started with a zero divisor completes in the cycle it is captured. The result reads 0, the sticky flag (control bit 5, read-only) is set, and the status reads 2 with busy clear.
- R8: A result read returns an error exactly when control bit 5 and the trap enable (control bit 3) are both set. Otherwise it returns the contents. Starting any new operation clears bit 5.
- R9: Writing the radicand register (address 3) starts a square root. The unit is busy for exactly 16 cycles with status 5, then shows status 1. The result is floor(sqrt(radicand)), zero-extended.
- R10: While the unit is busy, writes to the control, dividend, divisor and radicand registers are ignored. They neither change the stored values nor start an operation.
- R11: The status code only ever takes the values 0, 1, 2, 5 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register index: 0 control, 1 dividend, 2 divisor, 3 radicand, 4 result |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Always high; every request is taken in its cycle |
| rsp_rdata | output | 32 | Read data for the addressed register, 0 on error |
| rsp_error | output | 1 | Error response for the current read |

## Verification
Division is tried with small unsigned operands, with a full-scale dividend against a small divisor, and with all four sign combinations of a signed pair. The sign cases separate the quotient sign rule from the remainder sign rule, and the full-scale case exposes carries lost from the top bit. Square roots cover 0, 1, values just below and at a perfect square, and the largest radicand, which separates rounding from flooring and shows any root-bit overflow. The start-mode, zero-divisor and busy-write scenarios read back the operand registers and the status field, so that a start or a write that should have been dropped shows up at the port.

// File: rtl/divsqrt_pkg.sv
// Shared definitions for the divide/square-root unit: register indices,
// control-bit positions and the result source selector.
package divsqrt_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL     = 3'd0,
        REG_DIVIDEND = 3'd1,
        REG_DIVISOR  = 3'd2,
        REG_RADICAND = 3'd3,
        REG_RESULT   = 3'd4
    } reg_addr_e;

    // Control register bit positions
    localparam int CB_GO      = 0;
    localparam int CB_UNSIGN  = 1;
    localparam int CB_REMSEL  = 2;
    localparam int CB_DZTRAP  = 3;
    localparam int CB_DEFER   = 4;
    localparam int CB_DZFLAG  = 5;
    localparam int CB_ST_LO   = 29;   // status: [29] root, [30] divide, [31] busy

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_QUO  = 2'd1,
        SRC_REM  = 2'd2,
        SRC_ROOT = 2'd3
    } res_src_e;
endpackage

// File: rtl/divsqrt_divider.sv
// Restoring shift-subtract divider. On start (when idle) it takes both operands,
// converts them to magnitudes if signed, and runs W iterations, one per cycle.
// After the last iteration it applies the signs: the quotient is negated when the
// operand signs differ, and the remainder takes the dividend's sign.
// Assumes: the divisor is nonzero (the caller handles zero), and start is ignored while busy.
module divsqrt_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  quo_q, rem_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          negq_q, negr_q;
    logic          dvd_neg, dvs_neg;
    logic [W-1:0]  dvd_mag, dvs_mag;
    logic [W:0]    shifted, diff;
    logic          take;
    logic [W-1:0]  rem_nxt, quo_nxt;

    // Operand magnitudes and the next restoring step.
    always_comb begin
        dvd_neg = is_signed & dividend[W-1];
        dvs_neg = is_signed & divisor[W-1];
        dvd_mag = dvd_neg ? (~dividend + 1'b1) : dividend;
        dvs_mag = dvs_neg ? (~divisor + 1'b1) : divisor;
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        take    = ~diff[W];
        rem_nxt = take ? diff[W-1:0] : shifted[W-1:0];
        quo_nxt = {quo_q[W-2:0], take};
    end

    // Iteration state, and result capture on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            quo_q     <= '0;
            rem_q     <= '0;
            dvs_q     <= '0;
            cnt_q     <= '0;
            negq_q    <= 1'b0;
            negr_q    <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            quo_q  <= dvd_mag;
            rem_q  <= '0;
            dvs_q  <= dvs_mag;
            cnt_q  <= '0;
            negq_q <= dvd_neg ^ dvs_neg;
            negr_q <= dvd_neg;
        end else if (busy) begin
            quo_q <= quo_nxt;
            rem_q <= rem_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(W-1)) begin
                busy      <= 1'b0;
                quotient  <= negq_q ? (~quo_nxt + 1'b1) : quo_nxt;
                remainder <= negr_q ? (~rem_nxt + 1'b1) : rem_nxt;
            end
        end
    end
endmodule

// File: rtl/divsqrt_isqrt.sv
// Digit-by-digit integer square root. It consumes two radicand bits per cycle
// over W/2 cycles and produces floor(sqrt(radicand)) on a W/2-bit root.
// Assumes: W is even, and start is ignored while busy.
module divsqrt_isqrt #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   radicand,
    output logic           busy,
    output logic [W/2-1:0] root
);
    localparam int RW = W / 2;
    localparam int CW = $clog2(RW);

    logic [W-1:0]    rad_q;
    logic [RW+1:0]   rem_q;
    logic [RW-1:0]   root_q;
    logic [CW-1:0]   cnt_q;
    logic [RW+3:0]   rem_t, trial, sub;
    logic            ge;
    logic [RW+1:0]   rem_nxt;
    logic [RW-1:0]   root_nxt;

    // One root digit: bring down a bit pair and try subtracting (4*root + 1).
    always_comb begin
        rem_t    = {rem_q, rad_q[W-1:W-2]};
        trial    = {2'b00, root_q, 2'b01};
        ge       = (rem_t >= trial);
        sub      = rem_t - trial;
        rem_nxt  = ge ? sub[RW+1:0] : rem_t[RW+1:0];
        root_nxt = {root_q[RW-2:0], ge};
    end

    // Iteration state, and root capture on the final digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= '0;
            root   <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            rad_q  <= radicand;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= '0;
        end else if (busy) begin
            rad_q  <= {rad_q[W-3:0], 2'b00};
            rem_q  <= rem_nxt;
            root_q <= root_nxt;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CW'(RW-1)) begin
                busy <= 1'b0;
                root <= root_nxt;
            end
        end
    end
endmodule

// File: rtl/divsqrt_unit.sv
// Register front end of the divide/square-root unit. It holds the operand and
// control registers, decodes the two division start modes and the square-root
// start, handles a zero divisor without running the divider, and forms the read
// data, the packed status code and the result-read error.
// Assumes: one request per cycle, reads have no side effects, and every write
// is dropped while either engine is busy.
module divsqrt_unit
    import divsqrt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error
);
    localparam int RW = DATA_W / 2;

    logic              uns_q, remsel_q, trap_q, defer_q, dz_q;
    logic              op_root_q, op_div_q;
    logic [DATA_W-1:0] dvd_q, dvs_q, rad_q;
    res_src_e          src_q;

    logic              div_busy, root_busy, busy;
    logic [DATA_W-1:0] div_quo, div_rem;
    logic [RW-1:0]     root_val;

    logic              wr, div_go, div_zero, root_go, go_signed, go_remsel;
    logic [DATA_W-1:0] go_divisor, result_val, ctrl_val;
    logic [2:0]        status;

    assign req_ready = 1'b1;
    assign busy      = div_busy | root_busy;
    assign status    = {busy, op_div_q, op_root_q};

    // Start decode for both division modes and for the square root.
    always_comb begin
        wr         = req_valid & req_write & ~busy;
        div_go     = 1'b0;
        go_divisor = dvs_q;
        go_signed  = ~uns_q;
        go_remsel  = remsel_q;
        if (wr && req_addr == REG_DIVISOR && !defer_q) begin
            div_go     = 1'b1;
            go_divisor = req_wdata;
        end
        if (wr && req_addr == REG_CTRL && req_wdata[CB_GO] && req_wdata[CB_DEFER]) begin
            div_go    = 1'b1;
            go_signed = ~req_wdata[CB_UNSIGN];
            go_remsel = req_wdata[CB_REMSEL];
        end
        div_zero = (go_divisor == '0);
        root_go  = wr & (req_addr == REG_RADICAND);
    end

    divsqrt_divider #(.W(DATA_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_go & ~div_zero),
        .is_signed (go_signed),
        .dividend  (dvd_q),
        .divisor   (go_divisor),
        .busy      (div_busy),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    divsqrt_isqrt #(.W(DATA_W)) u_root (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (root_go),
        .radicand (rad_q_next_sel(req_wdata)),
        .busy     (root_busy),
        .root     (root_val)
    );

    // The radicand goes straight from the write data into the engine.
    function automatic logic [DATA_W-1:0] rad_q_next_sel(input logic [DATA_W-1:0] d);
        return d;
    endfunction

    // Register writes, operation bookkeeping and the divide-by-zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uns_q     <= 1'b0;
            remsel_q  <= 1'b0;
            trap_q    <= 1'b0;
            defer_q   <= 1'b0;
            dz_q      <= 1'b0;
            op_root_q <= 1'b0;
            op_div_q  <= 1'b0;
            dvd_q     <= '0;
            dvs_q     <= '0;
            rad_q     <= '0;
            src_q     <= SRC_NONE;
        end else begin
            if (wr) begin
                case (req_addr)
                    REG_CTRL: begin
                        uns_q    <= req_wdata[CB_UNSIGN];
                        remsel_q <= req_wdata[CB_REMSEL];
                        trap_q   <= req_wdata[CB_DZTRAP];
                        defer_q  <= req_wdata[CB_DEFER];
                    end
                    REG_DIVIDEND: dvd_q <= req_wdata;
                    REG_DIVISOR:  dvs_q <= req_wdata;
                    REG_RADICAND: rad_q <= req_wdata;
                    default: ;
                endcase
            end
            if (div_go) begin
                op_div_q  <= 1'b1;
                op_root_q <= 1'b0;
                dz_q      <= div_zero;
                src_q     <= div_zero ? SRC_NONE : (go_remsel ? SRC_REM : SRC_QUO);
            end
            if (root_go) begin
                op_div_q  <= 1'b0;
                op_root_q <= 1'b1;
                dz_q      <= 1'b0;
                src_q     <= SRC_ROOT;
            end
        end
    end

    // Result register view: selects the engine output recorded at start.
    always_comb begin
        case (src_q)
            SRC_QUO:  result_val = div_quo;
            SRC_REM:  result_val = div_rem;
            SRC_ROOT: result_val = {{(DATA_W-RW){1'b0}}, root_val};
            default:  result_val = '0;
        endcase
    end

    // Control/status read image.
    always_comb begin
        ctrl_val                      = '0;
        ctrl_val[CB_UNSIGN]           = uns_q;
        ctrl_val[CB_REMSEL]           = remsel_q;
        ctrl_val[CB_DZTRAP]           = trap_q;
        ctrl_val[CB_DEFER]            = defer_q;
        ctrl_val[CB_DZFLAG]           = dz_q;
        ctrl_val[CB_ST_LO+2:CB_ST_LO] = status;
    end

    // Read data and the trapped result-read error.
    always_comb begin
        rsp_error = req_valid & ~req_write & (req_addr == REG_RESULT) & dz_q & trap_q;
        rsp_rdata = '0;
        if (req_valid && !req_write && !rsp_error) begin
            case (req_addr)
                REG_CTRL:     rsp_rdata = ctrl_val;
                REG_DIVIDEND: rsp_rdata = dvd_q;
                REG_DIVISOR:  rsp_rdata = dvs_q;
                REG_RADICAND: rsp_rdata = rad_q;
                REG_RESULT:   rsp_rdata = result_val;
                default:      rsp_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/divsqrt_unit_chk.sv
// Property checker for divsqrt_unit, attached by the bind at the end of this file.
// It watches the port, the engine busy lines, the status code and the operand registers.
module divsqrt_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [2:0]        req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_error,
    input logic              busy,
    input logic              div_busy,
    input logic              root_busy,
    input logic              defer_q,
    input logic              dz_q,
    input logic [2:0]        status,
    input logic [DATA_W-1:0] result_val,
    input logic [DATA_W-1:0] dvd_q,
    input logic [DATA_W-1:0] dvs_q,
    input logic [DATA_W-1:0] rad_q,
    input logic [DATA_W/2-1:0] root_val
);
    localparam int CNTW = $clog2(DATA_W) + 2;

    logic [CNTW-1:0]   busy_cnt;
    logic [2*DATA_W+1:0] lo_sq, hi_sq, rad_ext;

    // Counts consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= '0;
        else        busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
    end

    // Squares bracketing the produced root.
    always_comb begin
        lo_sq   = (2*DATA_W+2)'(root_val) * (2*DATA_W+2)'(root_val);
        hi_sq   = ((2*DATA_W+2)'(root_val) + 1'b1) * ((2*DATA_W+2)'(root_val) + 1'b1);
        rad_ext = (2*DATA_W+2)'(rad_q);
    end

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status inside {3'd0, 3'd1, 3'd2, 3'd5, 3'd6}); // R11

    AST_DIV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_busy) |-> busy_cnt == CNTW'(DATA_W)); // R2

    AST_ROOT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(root_busy) |-> busy_cnt == CNTW'(DATA_W/2)); // R9

    AST_ROOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(root_busy) |-> (lo_sq <= rad_ext) && (hi_sq > rad_ext)); // R9

    AST_ERROR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> req_valid && !req_write && req_addr == 3'd4 && dz_q); // R8

    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dz_q) |-> result_val == '0 && !busy); // R7

    AST_FAST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 3'd2 && !busy && !defer_q && req_wdata != '0)
        |=> div_busy); // R5

    AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 3'd2 && !busy && defer_q) |=> !div_busy); // R6

    AST_BUSY_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dvd_q) && $stable(dvs_q) && $stable(rad_q)); // R10
endmodule

bind divsqrt_unit divsqrt_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_error  (rsp_error),
    .busy       (busy),
    .div_busy   (div_busy),
    .root_busy  (root_busy),
    .defer_q    (defer_q),
    .dz_q       (dz_q),
    .status     (status),
    .result_val (result_val),
    .dvd_q      (dvd_q),
    .dvs_q      (dvs_q),
    .rad_q      (rad_q),
    .root_val   (root_val)
);

// File: tb/divsqrt_unit_test.sv
// Directed bench for divsqrt_unit: one task per scenario, each checking its own results.
module divsqrt_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic        rsp_error;

    int nchk = 0;
    int nerr = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_DVD = 3'd1, A_DVS = 3'd2, A_RAD = 3'd3, A_RES = 3'd4;
    localparam logic [31:0] GO = 32'h1, UNS = 32'h2, REMS = 32'h4, TRAP = 32'h8, DEFER = 32'h10;

    always #4 clk = ~clk;   // 125 MHz

    divsqrt_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .rsp_error(rsp_error)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d, output logic e);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        d = rsp_rdata; e = rsp_error;
        req_valid = 1'b0;
    endtask

    // Polls status each cycle until idle; reports busy cycles, the final status, and whether any busy read differed from code.
    task automatic poll(input logic [2:0] code, output int n, output logic [2:0] last, output logic bad);
        logic [31:0] d; logic e;
        n = 0; bad = 1'b0;
        bus_rd(A_CTRL, d, e);
        while (d[31] && n < 200) begin
            if (d[31:29] != code) bad = 1'b1;
            n++;
            @(negedge clk);
            bus_rd(A_CTRL, d, e);
        end
        last = d[31:29];
    endtask

    function automatic logic [31:0] ref_root(input logic [31:0] x);
        longint lo = 0, hi = 65535, mid;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (mid * mid <= longint'(x)) lo = mid; else hi = mid - 1;
        end
        return 32'(lo);
    endfunction

    task automatic t_reset();
        logic [31:0] d; logic e;
        bus_rd(A_CTRL, d, e);  check("R1 ctrl", d, 32'h0);
        bus_rd(A_RES, d, e);   check("R1 result", d, 32'h0); check("R1 err", {31'b0, e}, 32'h0);
        bus_rd(A_DVD, d, e);   check("R1 dividend", d, 32'h0);
    endtask

    task automatic t_div(input logic [31:0] a, input logic [31:0] b, input bit uns, input bit rem, input string tag);
        logic [31:0] d, exp; logic e; int n; logic [2:0] last; logic bad;
        int sa, sb;
        sa = a; sb = b;
        if (uns) exp = rem ? (a % b) : (a / b);
        else     exp = rem ? 32'(sa % sb) : 32'(sa / sb);
        bus_wr(A_CTRL, (uns ? UNS : 32'h0) | (rem ? REMS : 32'h0));
        bus_wr(A_DVD, a);
        bus_wr(A_DVS, b);
        poll(3'd6, n, last, bad);
        check("R5 fast start busy cycles", 32'(n), 32'd32);
        check("R11 busy code", {31'b0, bad}, 32'h0);
        check("R2 idle code", {29'b0, last}, 32'd2);
        bus_rd(A_RES, d, e);
        check(tag, d, exp);
    endtask

    task automatic t_defer();
        logic [31:0] d; logic e; int n; logic [2:0] last; logic bad;
        bus_wr(A_CTRL, DEFER | UNS);
        bus_wr(A_DVD, 32'd77);
        bus_wr(A_DVS, 32'd5);
        bus_rd(A_CTRL, d, e);  check("R6 no start on divisor", {31'b0, d[31]}, 32'h0);
        @(negedge clk);
        bus_rd(A_CTRL, d, e);  check("R6 still idle", {31'b0, d[31]}, 32'h0);
        bus_wr(A_CTRL, DEFER | UNS | REMS | GO);
        poll(3'd6, n, last, bad);
        check("R6 go busy cycles", 32'(n), 32'd32);
        bus_rd(A_RES, d, e);   check("R6 R4 remainder via go", d, 32'd2);
        bus_wr(A_CTRL, DEFER | UNS | GO);
        poll(3'd6, n, last, bad);
        bus_rd(A_RES, d, e);   check("R6 quotient via go", d, 32'd15);
    endtask

    task automatic t_busy_writes();
        logic [31:0] d, r0; logic e; int n; logic [2:0] last; logic bad;
        bus_wr(A_CTRL, UNS);
        bus_wr(A_DVD, 32'd1000);
        bus_rd(A_RAD, r0, e);
        bus_wr(A_DVS, 32'd10);
        bus_wr(A_DVD, 32'd5);
        bus_wr(A_CTRL, DEFER | REMS | GO);
        bus_wr(A_RAD, 32'd49);
        bus_wr(A_DVS, 32'd3);
        bus_rd(A_DVD, d, e);   check("R10 dividend kept", d, 32'd1000);
        bus_rd(A_DVS, d, e);   check("R10 divisor kept", d, 32'd10);
        bus_rd(A_RAD, d, e);   check("R10 radicand kept", d, r0);
        bus_rd(A_CTRL, d, e);  check("R10 still dividing", {29'b0, d[31:29]}, 32'd6);
        check("R10 ctrl bits kept", {27'b0, d[4:0]}, 32'h2);
        poll(3'd6, n, last, bad);
        bus_rd(A_RES, d, e);   check("R10 quotient unaffected", d, 32'd100);
    endtask

    task automatic t_zero();
        logic [31:0] d; logic e; int n; logic [2:0] last; logic bad;
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_DVD, 32'd55);
        bus_wr(A_DVS, 32'd0);
        bus_rd(A_CTRL, d, e);
        check("R7 status idle div", {29'b0, d[31:29]}, 32'd2);
        check("R7 flag set", {31'b0, d[5]}, 32'h1);
        bus_rd(A_RES, d, e);
        check("R7 result zero", d, 32'h0);
        check("R8 no trap no error", {31'b0, e}, 32'h0);
        bus_wr(A_CTRL, TRAP);
        bus_rd(A_RES, d, e);   check("R8 trapped error", {31'b0, e}, 32'h1);
        bus_rd(A_CTRL, d, e);  check("R8 ctrl read no error", {31'b0, e}, 32'h0);
        bus_wr(A_DVS, 32'd5);
        poll(3'd6, n, last, bad);
        bus_rd(A_RES, d, e);
        check("R8 flag cleared err", {31'b0, e}, 32'h0);
        check("R8 new result", d, 32'd11);
        bus_wr(A_CTRL, 32'h0);
    endtask

    task automatic t_root(input logic [31:0] x);
        logic [31:0] d; logic e; int n; logic [2:0] last; logic bad;
        bus_wr(A_RAD, x);
        poll(3'd5, n, last, bad);
        check("R9 busy cycles", 32'(n), 32'd16);
        check("R11 root busy code", {31'b0, bad}, 32'h0);
        check("R9 idle code", {29'b0, last}, 32'd1);
        bus_rd(A_RES, d, e);
        check("R9 root", d, ref_root(x));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_div(32'd100, 32'd7, 1, 0, "R2 unsigned quotient");
        t_div(32'd100, 32'd7, 1, 1, "R4 unsigned remainder");
        t_div(32'hFFFF_FFFF, 32'h10, 1, 0, "R2 full-scale quotient");
        t_div(32'hFFFF_FFFF, 32'h10, 1, 1, "R4 full-scale remainder");
        t_div(-32'sd7, 32'd2, 0, 0, "R3 neg/pos quotient");
        t_div(-32'sd7, 32'd2, 0, 1, "R3 neg/pos remainder");
        t_div(32'd7, -32'sd2, 0, 0, "R3 pos/neg quotient");
        t_div(32'd7, -32'sd2, 0, 1, "R3 pos/neg remainder");
        t_div(-32'sd7, -32'sd2, 0, 0, "R3 neg/neg quotient");
        t_div(-32'sd7, -32'sd2, 0, 1, "R3 neg/neg remainder");
        t_defer();
        t_busy_writes();
        t_zero();
        t_root(32'd0);
        t_root(32'd1);
        t_root(32'd15);
        t_root(32'd16);
        t_root(32'd1000000);
        t_root(32'hFFFF_FFFF);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule